// File: doc/BRIEF.md
# Radio Calibration Retention Table Controller

This block holds calibration words for up to three receive chains and can replay them to the radio when asked. Every chain owns six 28-bit entries: three DC offset values (loop, low and high), one filter value, one receive gain setting and one peak detector offset. Software fills and inspects the entries through a per-chain pair of registers. One holds the command and the other holds the data word. A global control register turns retention on, chooses entries to leave out of a replay, and launches a forced replay.

A table access is started by writing a command with its go bit set. The go bit reads back as 1 while the access runs and returns to 0 when it completes. A forced replay walks every chain in ascending order, and within each chain every entry that is not masked in ascending index order. It drives one entry per clock on the replay bus. The force bit reads back as 1 for the whole walk and drops by itself afterwards.

Two small state machines do the work. Each chain's access port has the states ACC_IDLE and ACC_BUSY. An accepted go command moves it from ACC_IDLE to ACC_BUSY. It returns to ACC_IDLE when its latency counter reaches zero, and performs the read or write on that edge. The replay walker has the states WLK_IDLE and WLK_RUN. A force request with at least one unmasked entry moves it from WLK_IDLE to WLK_RUN. It goes back to WLK_IDLE after it drives the last unmasked entry of the last chain.

Top module: `cal_retain_ctrl`

## Requirements
- R1: After reset, every register reads 0, every table entry is 0 and `rsto_valid` is 0.
- R2: Word address 0 is the control register: bit 0 enables retention, bits 6:1 form the replay mask (bit 1+k covers entry k), and bit 7 is force. Chain c has its command register at address 2c+1, with bit 0 as go, bit 1 as direction (1 = write, 0 = read) and bits 4:2 as the entry index. Chain c has its data register at address 2c+2, which holds the entry value in bits 31:4 and reads bits 3:0 as 0. Unmapped addresses read 0.
- R3: When a go command is accepted, the go bit reads 1 for exactly two cycles after the write edge and reads 0 from then on.
- R4: A write access stores the data register value into the selected entry when it completes.
- R5: A read access loads the selected entry into the data register, and the value is visible once go has cleared.
- R6: While an access is busy, writes to that chain's command and data registers are ignored.
- R7: A go command issued while retention is disabled is ignored: go stays 0 and the table is left unchanged. The direction and index fields are still updated.
- R8: A forced replay drives chains in ascending order and entries in ascending index order, one per cycle. Each beat carries valid, chain, index and the stored data, and the first beat appears in the cycle after the write.
- R9: Entries whose mask bit is set are never driven and take no cycles.
- R10: The force bit reads 1 in every cycle in which a beat is driven and reads 0 from the cycle after the last beat. If every entry is masked, no beat is driven and the force bit reads 0 straight away.
- R11: A force request written together with enable = 0 starts no replay.
- R12: While a replay runs, writes to the control, command and data registers are ignored.
- R13: Entry indices 6 and 7 are accepted and complete normally, but a write to them stores nothing and a read of them returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rsto_valid | output | 1 | Replay beat valid |
| rsto_chain | output | 2 | Chain of the current beat |
| rsto_index | output | 3 | Entry index of the current beat |
| rsto_data | output | 28 | Stored entry value of the current beat |

## Verification
A wrong access latency counter shows up on the go bit within two cycles of the command. A wrong index or direction register first surfaces when the affected entry is read back or replayed. The replay walker's chain and entry pointers are visible on the replay bus every cycle. A pointer that skips an entry, repeats one or crosses a chain boundary late therefore shows as a beat mismatch in the very cycle it happens. A stale mask copy in the walker shows as a masked entry being driven.

// File: rtl/cal_retain_pkg.sv
package cal_retain_pkg;
    localparam int CR_CHAINS   = 3;
    localparam int CR_ENTRIES  = 6;
    localparam int CR_DATA_W   = 28;
    localparam int CR_ACC_LAT  = 2;
    localparam int CR_REG_W    = 32;

    localparam int CR_GO_BIT   = 0;
    localparam int CR_DIR_BIT  = 1;
    localparam int CR_IDX_LSB  = 2;
    localparam int CR_IDX_W    = 3;

    localparam int CR_EN_BIT   = 0;
    localparam int CR_MASK_LSB = 1;

    typedef enum logic {ACC_IDLE, ACC_BUSY} acc_state_e;
    typedef enum logic {WLK_IDLE, WLK_RUN}  wlk_state_e;
endpackage

// File: rtl/cal_access_port.sv
module cal_access_port
    import cal_retain_pkg::*;
#(
    parameter int ENTRIES = CR_ENTRIES,
    parameter int DATA_W  = CR_DATA_W,
    parameter int ACC_LAT = CR_ACC_LAT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            retain_en,
    input  logic                            hold,
    input  logic                            cmd_we,
    input  logic                            data_we,
    input  logic [CR_REG_W-1:0]             wdata,
    output logic                            busy,
    output logic [CR_REG_W-1:0]             cmd_rd,
    output logic [CR_REG_W-1:0]             data_rd,
    output logic [ENTRIES-1:0][DATA_W-1:0]  entries
);
    localparam int CNT_W = $clog2(ACC_LAT + 1);
    localparam int DLSB  = CR_REG_W - DATA_W;

    acc_state_e                    st_q, st_d;
    logic [CNT_W-1:0]              cnt_q;
    logic                          dir_q;
    logic [CR_IDX_W-1:0]           idx_q;
    logic [DATA_W-1:0]             dreg_q;
    logic [ENTRIES-1:0][DATA_W-1:0] tbl_q;
    logic                          accept, launch, finish;
    logic [DATA_W-1:0]             rd_word;

    assign accept = cmd_we && (st_q == ACC_IDLE) && !hold;
    assign launch = accept && wdata[CR_GO_BIT] && retain_en;
    assign finish = (st_q == ACC_BUSY) && (cnt_q == '0);

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (idx_q == CR_IDX_W'(k)) rd_word = tbl_q[k];
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE: if (launch) st_d = ACC_BUSY;
            ACC_BUSY: if (finish) st_d = ACC_IDLE;
            default:  st_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ACC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            idx_q  <= '0;
            dreg_q <= '0;
            tbl_q  <= '0;
        end else begin
            if (accept) begin
                dir_q <= wdata[CR_DIR_BIT];
                idx_q <= wdata[CR_IDX_LSB +: CR_IDX_W];
            end
            if (launch)
                cnt_q <= CNT_W'(ACC_LAT - 1);
            else if (st_q == ACC_BUSY && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (data_we && st_q == ACC_IDLE && !hold)
                dreg_q <= wdata[CR_REG_W-1:DLSB];
            else if (finish && !dir_q)
                dreg_q <= rd_word;
            for (int k = 0; k < ENTRIES; k++) begin
                if (finish && dir_q && idx_q == CR_IDX_W'(k)) tbl_q[k] <= dreg_q;
            end
        end
    end

    always_comb begin
        cmd_rd = '0;
        cmd_rd[CR_GO_BIT]                  = (st_q == ACC_BUSY);
        cmd_rd[CR_DIR_BIT]                 = dir_q;
        cmd_rd[CR_IDX_LSB +: CR_IDX_W]     = idx_q;
        data_rd = {dreg_q, {DLSB{1'b0}}};
    end

    assign busy    = (st_q == ACC_BUSY);
    assign entries = tbl_q;
endmodule

// File: rtl/cal_restore_walk.sv
module cal_restore_walk
    import cal_retain_pkg::*;
#(
    parameter int CHAINS  = CR_CHAINS,
    parameter int ENTRIES = CR_ENTRIES,
    parameter int DATA_W  = CR_DATA_W,
    parameter int CH_W    = (CHAINS > 1) ? $clog2(CHAINS) : 1
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start,
    input  logic [ENTRIES-1:0]                         start_mask,
    input  logic [CHAINS-1:0][ENTRIES-1:0][DATA_W-1:0] table_in,
    output logic                                       active,
    output logic                                       o_valid,
    output logic [CH_W-1:0]                            o_chain,
    output logic [CR_IDX_W-1:0]                        o_index,
    output logic [DATA_W-1:0]                          o_data
);
    wlk_state_e          st_q, st_d;
    logic [ENTRIES-1:0]  mask_q, srch;
    logic [CH_W-1:0]     chain_q;
    logic [CR_IDX_W-1:0] ent_q, first_ix, next_ix;
    logic                any_free, has_next, last_chain;

    always_comb begin
        srch     = (st_q == WLK_IDLE) ? start_mask : mask_q;
        first_ix = '0;
        any_free = 1'b0;
        next_ix  = '0;
        has_next = 1'b0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (!srch[k]) begin
                first_ix = CR_IDX_W'(k);
                any_free = 1'b1;
            end
            if (!mask_q[k] && k > int'(ent_q)) begin
                next_ix  = CR_IDX_W'(k);
                has_next = 1'b1;
            end
        end
    end

    assign last_chain = (chain_q == CH_W'(CHAINS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WLK_IDLE: if (start && any_free)       st_d = WLK_RUN;
            WLK_RUN:  if (!has_next && last_chain) st_d = WLK_IDLE;
            default:  st_d = WLK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WLK_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            chain_q <= '0;
            ent_q   <= '0;
        end else if (st_q == WLK_IDLE) begin
            if (start) begin
                mask_q  <= start_mask;
                chain_q <= '0;
                ent_q   <= first_ix;
            end
        end else if (has_next) begin
            ent_q <= next_ix;
        end else if (!last_chain) begin
            chain_q <= chain_q + 1'b1;
            ent_q   <= first_ix;
        end
    end

    always_comb begin
        o_data = '0;
        for (int c = 0; c < CHAINS; c++) begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (chain_q == CH_W'(c) && ent_q == CR_IDX_W'(k)) o_data = table_in[c][k];
            end
        end
    end

    assign active  = (st_q == WLK_RUN);
    assign o_valid = active;
    assign o_chain = chain_q;
    assign o_index = ent_q;
endmodule

// File: rtl/cal_retain_ctrl.sv
module cal_retain_ctrl
    import cal_retain_pkg::*;
#(
    parameter int CHAINS  = CR_CHAINS,
    parameter int ENTRIES = CR_ENTRIES,
    parameter int DATA_W  = CR_DATA_W,
    parameter int ACC_LAT = CR_ACC_LAT,
    parameter int ADDR_W  = $clog2(2 * CHAINS + 1),
    parameter int CH_W    = (CHAINS > 1) ? $clog2(CHAINS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CR_REG_W-1:0]  reg_wdata,
    output logic [CR_REG_W-1:0]  reg_rdata,
    output logic                 rsto_valid,
    output logic [CH_W-1:0]      rsto_chain,
    output logic [CR_IDX_W-1:0]  rsto_index,
    output logic [DATA_W-1:0]    rsto_data
);
    localparam int FORCE_BIT = CR_MASK_LSB + ENTRIES;

    logic                                       ctl_en;
    logic [ENTRIES-1:0]                         ctl_mask;
    logic                                       walk_active;
    logic                                       ctl_upd, walk_go;
    logic [CHAINS-1:0]                          acc_busy;
    logic [CHAINS-1:0][CR_REG_W-1:0]            cmd_rd, data_rd;
    logic [CHAINS-1:0][ENTRIES-1:0][DATA_W-1:0] tbl_all;

    assign ctl_upd = reg_en && reg_we && (reg_addr == '0) && !walk_active;
    assign walk_go = ctl_upd && reg_wdata[FORCE_BIT] && reg_wdata[CR_EN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_mask <= '0;
        end else if (ctl_upd) begin
            ctl_en   <= reg_wdata[CR_EN_BIT];
            ctl_mask <= reg_wdata[CR_MASK_LSB +: ENTRIES];
        end
    end

    for (genvar g = 0; g < CHAINS; g++) begin : g_chain
        logic cmd_we, data_we;
        assign cmd_we  = reg_en && reg_we && (reg_addr == ADDR_W'(2 * g + 1));
        assign data_we = reg_en && reg_we && (reg_addr == ADDR_W'(2 * g + 2));

        cal_access_port #(
            .ENTRIES (ENTRIES),
            .DATA_W  (DATA_W),
            .ACC_LAT (ACC_LAT)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .retain_en (ctl_en),
            .hold      (walk_active),
            .cmd_we    (cmd_we),
            .data_we   (data_we),
            .wdata     (reg_wdata),
            .busy      (acc_busy[g]),
            .cmd_rd    (cmd_rd[g]),
            .data_rd   (data_rd[g]),
            .entries   (tbl_all[g])
        );
    end

    cal_restore_walk #(
        .CHAINS  (CHAINS),
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W),
        .CH_W    (CH_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (walk_go),
        .start_mask (reg_wdata[CR_MASK_LSB +: ENTRIES]),
        .table_in   (tbl_all),
        .active     (walk_active),
        .o_valid    (rsto_valid),
        .o_chain    (rsto_chain),
        .o_index    (rsto_index),
        .o_data     (rsto_data)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata[CR_EN_BIT]                = ctl_en;
            reg_rdata[CR_MASK_LSB +: ENTRIES]   = ctl_mask;
            reg_rdata[FORCE_BIT]                = walk_active;
        end
        for (int c = 0; c < CHAINS; c++) begin
            if (reg_addr == ADDR_W'(2 * c + 1)) reg_rdata = cmd_rd[c];
            if (reg_addr == ADDR_W'(2 * c + 2)) reg_rdata = data_rd[c];
        end
    end
endmodule

// File: rtl/cal_retain_chk.sv
module cal_retain_chk #(
    parameter int CHAINS  = 3,
    parameter int ENTRIES = 6,
    parameter int CH_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_en,
    input logic [ENTRIES-1:0] ctl_mask,
    input logic [CHAINS-1:0]  acc_busy,
    input logic               walk_active,
    input logic               rsto_valid,
    input logic [CH_W-1:0]    rsto_chain,
    input logic [2:0]         rsto_index
);
    for (genvar g = 0; g < CHAINS; g++) begin : g_acc
        p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
            acc_busy[g] && $past(acc_busy[g]) |=> !acc_busy[g]);
        p_go_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(acc_busy[g]) |-> $past(ctl_en));
        p_no_go_in_walk_r12: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(acc_busy[g]) |-> !$past(walk_active));
    end

    p_walk_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsto_valid |-> ctl_en);
    p_mask_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsto_valid |-> ((ctl_mask >> rsto_index) & ENTRIES'(1)) == '0);
    p_chain_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsto_valid && $past(rsto_valid) |-> rsto_chain >= $past(rsto_chain));
    p_index_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsto_valid && $past(rsto_valid) && rsto_chain == $past(rsto_chain)
        |-> rsto_index > $past(rsto_index));
endmodule

bind cal_retain_ctrl cal_retain_chk #(
    .CHAINS  (CHAINS),
    .ENTRIES (ENTRIES),
    .CH_W    (CH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_en      (ctl_en),
    .ctl_mask    (ctl_mask),
    .acc_busy    (acc_busy),
    .walk_active (walk_active),
    .rsto_valid  (rsto_valid),
    .rsto_chain  (rsto_chain),
    .rsto_index  (rsto_index)
);

// File: tb/tb_cal_retain_ctrl.sv
`timescale 1ns/1ps
module tb_cal_retain_ctrl;
    localparam int CH = 3;
    localparam int EN = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rsto_valid;
    logic [1:0]  rsto_chain;
    logic [2:0]  rsto_index;
    logic [27:0] rsto_data;

    cal_retain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rsto_valid(rsto_valid), .rsto_chain(rsto_chain),
        .rsto_index(rsto_index), .rsto_data(rsto_data)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int checks = 0, errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    logic [27:0] mtbl [CH][EN];
    logic [27:0] mdreg [CH];
    int          midx [CH];
    int          mdir [CH];
    int          acc_end [CH];
    int          men = 0, mmask = 0, walk_end = 0;
    int qc[$], qi[$];
    logic [27:0] qd[$];

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [27:0] pat(int c, int e);
        logic [31:0] v;
        v = (c * 7 + e + 1) * 32'h0135_79B1;
        return v[27:0];
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        logic [31:0] v;
        int c;
        v = '0;
        if (a == 0) begin
            v[0]   = men[0];
            v[6:1] = mmask[5:0];
            v[7]   = (cyc < walk_end);
        end else if (a <= 2 * CH) begin
            if (a % 2 == 1) begin
                c = (a - 1) / 2;
                v[0]   = (cyc < acc_end[c]);
                v[1]   = mdir[c][0];
                v[4:2] = midx[c][2:0];
            end else begin
                c = (a - 2) / 2;
                v = {mdreg[c], 4'h0};
            end
        end
        return v;
    endfunction

    // per-cycle comparison of the replay bus against the expected beat queue
    int ec, ei;
    logic [27:0] ed;
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            checks++;
            if (qc.size() > 0) begin
                ec = qc.pop_front(); ei = qi.pop_front(); ed = qd.pop_front();
                if (rsto_valid !== 1'b1 || rsto_chain !== ec[1:0] ||
                    rsto_index !== ei[2:0] || rsto_data !== ed) begin
                    errors++;
                    $display("FAIL R8 R9 beat: got v=%0b ch=%0d ix=%0d d=%h expected v=1 ch=%0d ix=%0d d=%h",
                             rsto_valid, rsto_chain, rsto_index, rsto_data, ec, ei, ed);
                end
            end else if (rsto_valid !== 1'b0) begin
                errors++;
                $display("FAIL R10 idle bus: got valid=%0b expected 0", rsto_valid);
            end
        end
    end

    task automatic rd(int a, output logic [31:0] v);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = 3'(a);
        #0.5;
        v = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        int e, c, n;
        bit walking, busy;
        @(negedge clk);
        e = cyc + 1;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        walking = (e <= walk_end);
        if (a == 0) begin
            if (!walking) begin
                men = int'(d[0]);
                mmask = int'(d[6:1]);
                if (d[7] && d[0]) begin
                    n = 0;
                    for (int cc = 0; cc < CH; cc++)
                        for (int k = 0; k < EN; k++)
                            if (!mmask[k]) begin
                                qc.push_back(cc); qi.push_back(k); qd.push_back(mtbl[cc][k]);
                                n++;
                            end
                    if (n > 0) walk_end = e + n;
                end
            end
        end else if (a % 2 == 1) begin
            c = (a - 1) / 2;
            busy = (e <= acc_end[c]);
            if (!busy && !walking) begin
                midx[c] = int'(d[4:2]);
                mdir[c] = int'(d[1]);
                if (d[0] && men != 0) begin
                    acc_end[c] = e + 2;
                    if (mdir[c] != 0) begin
                        if (midx[c] < EN) mtbl[c][midx[c]] = mdreg[c];
                    end else begin
                        mdreg[c] = (midx[c] < EN) ? mtbl[c][midx[c]] : 28'h0;
                    end
                end
            end
        end else begin
            c = (a - 2) / 2;
            busy = (e <= acc_end[c]);
            if (!busy && !walking) mdreg[c] = d[31:4];
        end
    endtask

    task automatic wait_walk();
        while (qc.size() > 0) @(negedge clk);
        tick(1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < CH; c++) begin
            mdreg[c] = '0; midx[c] = 0; mdir[c] = 0; acc_end[c] = 0;
            for (int k = 0; k < EN; k++) mtbl[c][k] = '0;
        end
        tick(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick(1);

        // R1: reset state of every register
        for (int a = 0; a <= 2 * CH; a++) begin
            rd(a, v); chk("R1 reset read", v, 32'h0);
        end
        rd(7, v); chk("R2 unmapped read", v, 32'h0);

        // R3 latency, R4 write path, with enable set
        wr(0, 32'h1);
        wr(2, {pat(0, 0), 4'h0});
        wr(1, 32'h3 | (0 << 2));
        rd(1, v); chk("R3 go high cycle 1", {31'h0, v[0]}, 32'h1);
        tick(1);
        rd(1, v); chk("R3 go high cycle 2", {31'h0, v[0]}, 32'h1);
        tick(1);
        rd(1, v); chk("R3 go cleared", {31'h0, v[0]}, 32'h0);
        chk("R2 command readback", v, exp_rd(1));

        // fill every entry of every chain
        for (int c = 0; c < CH; c++)
            for (int k = 0; k < EN; k++) begin
                wr(2 * c + 2, {pat(c, k), 4'h0});
                wr(2 * c + 1, 32'h3 | (k << 2));
                tick(2);
            end

        // R5 read-back, R2 low nibble zero
        for (int c = 0; c < CH; c++) begin
            wr(2 * c + 2, 32'hFFFF_FFF0);
            wr(2 * c + 1, 32'h1 | ((c + 3) << 2));
            tick(2);
            rd(2 * c + 2, v);
            chk("R5 read entry", v, {pat(c, c + 3), 4'h0});
            chk("R2 data low bits", {28'h0, v[3:0]}, 32'h0);
        end

        // R7: go while disabled is ignored, table unchanged
        wr(0, 32'h0);
        wr(4, {28'h0ABCDEF, 4'h0});
        wr(3, 32'h3 | (3 << 2));
        rd(3, v); chk("R7 go stays clear", {31'h0, v[0]}, 32'h0);
        chk("R7 fields updated", v, exp_rd(3));
        wr(0, 32'h1);
        wr(3, 32'h1 | (3 << 2));
        tick(2);
        rd(4, v); chk("R7 entry unchanged", v, {pat(1, 3), 4'h0});

        // R6: writes during a busy access are ignored
        wr(2, {28'h1234567, 4'h0});
        wr(1, 32'h3 | (2 << 2));
        wr(2, {28'h7654321, 4'h0});
        wr(1, 32'h1 | (4 << 2));
        tick(1);
        rd(1, v); chk("R6 command kept", v, exp_rd(1));
        rd(2, v); chk("R6 data kept", v, {28'h1234567, 4'h0});
        wr(1, 32'h1 | (2 << 2));
        tick(2);
        rd(2, v); chk("R4 R6 entry written once", v, {28'h1234567, 4'h0});

        // R13: out-of-range indices
        wr(2, {28'h5555555, 4'h0});
        wr(1, 32'h3 | (6 << 2));
        tick(2);
        wr(1, 32'h1 | (7 << 2));
        rd(1, v); chk("R13 index 7 accepted", {31'h0, v[0]}, 32'h1);
        tick(2);
        rd(2, v); chk("R13 read index 7", v, 32'h0);

        // R8, R10: full replay, no mask
        wr(0, 32'h81);
        rd(0, v); chk("R10 force high", {31'h0, v[7]}, 32'h1);
        wait_walk();
        rd(0, v); chk("R10 force cleared", v, 32'h1);

        // R12: writes during a replay are ignored
        wr(0, 32'h81);
        wr(0, 32'h0);
        wr(5, 32'h3 | (5 << 2));
        wr(6, 32'hAAAA_AAA0);
        rd(5, v); chk("R12 command ignored", v, exp_rd(5));
        rd(6, v); chk("R12 data ignored", v, exp_rd(6));
        rd(0, v); chk("R12 control ignored", v, 32'h81);
        wait_walk();

        // R9: masked entries skipped (mask 6'b100101 -> entries 1,3,4)
        wr(0, 32'h1 | (6'b100101 << 1) | 32'h80);
        rd(0, v); chk("R9 control mask", v, exp_rd(0));
        wait_walk();
        rd(0, v); chk("R9 force cleared", {31'h0, v[7]}, 32'h0);

        // R10: everything masked
        wr(0, 32'h1 | (6'h3F << 1) | 32'h80);
        rd(0, v); chk("R10 all masked", v, 32'h7F);
        tick(3);

        // R11: force with enable 0
        wr(0, 32'h80);
        rd(0, v); chk("R11 no replay", v, 32'h0);
        tick(4);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule